// File: doc/BRIEF.md
# Protected System Clock Control Register

This block holds the 8-bit system clock control word of a chip's clock generator and turns its fields into the controls the clock tree needs. These are the clock-output pin function, peripheral clock gating in wait mode, the main oscillator enable, the sub-oscillator enable and drive level, the watchdog action, and the CPU clock source choice. Software writes the word through a plain write strobe and reads it back at any time with no side effects. Every write passes a per-bit filter. A global write-protect enable must be open. A clock-change lock freezes the three fields that can disturb the running clock. The watchdog action bit can only be set. A write that would switch the CPU clock source while it also moves an oscillator control is refused for that bit and recorded in a sticky error flag.

Beside the control word sits a 5-bit divide-ratio register for the main clock path. It is forced to divide-by-8 whenever software stops the main oscillator, except in on-chip-oscillator mode. A stop-mode entry pulse raises the sub-oscillator drive bit. The clock-output pin is fed from the sub clock fC or from free-running divide-by-8 and divide-by-32 taps of the input clock. The pin's selector takes a new setting only when the divide-by-32 counter wraps, so the pin never carries a cut pulse.

Top module: `clkctl_top`

## Requirements
- R1: After reset the control word reads 8'h08 (only bit 3 set), the divide ratio reads 5'b01000, the sequence error flag is 0 and the clock output pin is 0.
- R2: A write strobe (`wr_en` or `div_wr_en`) changes nothing unless `prot_en` is 1 in that cycle; the new value is visible on the next cycle.
- R3: While `chg_lock` is 1, writes leave bits 2, 5 and 7 unchanged while bits 0, 1, 3, 4 and 6 still take the written value.
- R4: Bit 6 (watchdog action, 1 = reset) is set-only: writing 0 never clears it, only reset does.
- R5: An accepted, unlocked write with bit 5 = 1 sets the divide ratio to 5'b01000 unless `oco_mode` is 1; this force wins over a divide-ratio write in the same cycle.
- R6: A one-cycle `stop_entry` pulse sets bit 3 to 1, whatever is written to bit 3 in the same cycle.
- R7: Bits 1:0 select the clock output: 00 = constant 0, 01 = `fc_in`, 10 = bit 2 of the free-running 5-bit counter (divide by 8), 11 = bit 4 (divide by 32). The counter is 0 at reset and counts every cycle. A new selection takes effect only on the edge where the counter wraps from 31 to 0.
- R8: `cpu_sub_sel` equals bit 7, `main_osc_run` is the inverse of bit 5, `xc_osc_en` equals bit 4 and `xc_drive_hi` equals bit 3.
- R9: `periph_run` is 0 only when `wait_mode` is 1 and bit 2 is 1; `fc32_run` is always 1.
- R10: If an accepted write would change bit 7 while bit 4 or bit 5 also changes, bit 7 keeps its old value, the other bits update, and `seq_err` becomes 1 and stays 1 until reset.
- R11: An accepted `div_wr_en` loads `div_wr_data` into the divide ratio, readable on `div_ratio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the source of the divided output taps |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write data |
| prot_en | input | 1 | Write-protect enable, 1 lets writes through |
| chg_lock | input | 1 | Clock-change lock for bits 2, 5, 7 |
| oco_mode | input | 1 | Running from the on-chip oscillator |
| stop_entry | input | 1 | One-cycle pulse on stop-mode entry |
| wait_mode | input | 1 | Chip is in wait mode |
| div_wr_en | input | 1 | Divide ratio write strobe |
| div_wr_data | input | 5 | Divide ratio write data |
| fc_in | input | 1 | Sub clock fC, seen as a signal |
| rd_data | output | 8 | Current control word |
| div_ratio | output | 5 | Current divide ratio |
| seq_err | output | 1 | Sticky refused clock-switch flag |
| clk_out | output | 1 | Clock output pin value |
| cpu_sub_sel | output | 1 | 1 = CPU runs from the sub clock |
| main_osc_run | output | 1 | Main oscillator enable |
| xc_osc_en | output | 1 | Sub oscillator pin function enable |
| xc_drive_hi | output | 1 | Sub oscillator high drive |
| wdt_reset_mode | output | 1 | Watchdog action is reset |
| periph_run | output | 1 | Peripheral clocks enabled |
| fc32_run | output | 1 | fC32 clock enabled |

## Verification
The assertions check on every cycle that closed protection freezes both registers, that the lock holds bits 2, 5 and 7, that the watchdog and error bits only rise, that stop entry leaves bit 3 high, and that an unlocked main-oscillator stop leaves divide-by-8 behind. Only the bench's sweeps can show the exact stored value of every byte under each protect and lock setting, including the refused clock switches. Only they can show the cycle on which a new output selection appears after the counter wraps, and the interplay of the force with divide-ratio writes and on-chip-oscillator mode.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   localparam int CW_W     = 8;
   localparam int B_PGATE  = 2;
   localparam int B_XDRV   = 3;
   localparam int B_XCEN   = 4;
   localparam int B_MSTOP  = 5;
   localparam int B_WDRST  = 6;
   localparam int B_CPUSUB = 7;
   localparam logic [CW_W-1:0] CW_RST = 8'h08;

   typedef enum logic [1:0] {
      OSEL_PORT = 2'b00,
      OSEL_FC   = 2'b01,
      OSEL_FA   = 2'b10,
      OSEL_FB   = 2'b11
   } osel_e;
endpackage

// File: rtl/clkctl_wfilter.sv
module clkctl_wfilter
   import clkctl_pkg::*;
(
   input  logic [CW_W-1:0] cur,
   input  logic            wr_en,
   input  logic [CW_W-1:0] wr_data,
   input  logic            prot_en,
   input  logic            chg_lock,
   input  logic            oco_mode,
   input  logic            stop_entry,
   output logic [CW_W-1:0] nxt,
   output logic            force_div,
   output logic            conflict
);
   logic            acc;
   logic [CW_W-1:0] cand;
   logic            chg_src;
   logic            chg_osc;

   assign acc = wr_en & prot_en;

   always_comb begin
      cand = acc ? wr_data : cur;
      if (chg_lock) begin
         cand[B_PGATE]  = cur[B_PGATE];
         cand[B_MSTOP]  = cur[B_MSTOP];
         cand[B_CPUSUB] = cur[B_CPUSUB];
      end
      cand[B_WDRST] = cur[B_WDRST] | (acc & wr_data[B_WDRST]);
      chg_src  = cand[B_CPUSUB] ^ cur[B_CPUSUB];
      chg_osc  = (cand[B_XCEN] ^ cur[B_XCEN]) | (cand[B_MSTOP] ^ cur[B_MSTOP]);
      conflict = chg_src & chg_osc;
      if (conflict)
         cand[B_CPUSUB] = cur[B_CPUSUB];
      if (stop_entry)
         cand[B_XDRV] = 1'b1;
      nxt = cand;
   end

   assign force_div = acc & ~chg_lock & wr_data[B_MSTOP] & ~oco_mode;
endmodule

// File: rtl/clkctl_store.sv
module clkctl_store
   import clkctl_pkg::*;
#(
   parameter int              DIV_W     = 5,
   parameter logic [DIV_W-1:0] DIV_RST   = 5'b01000,
   parameter logic [DIV_W-1:0] DIV_FORCE = 5'b01000
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW_W-1:0]  nxt,
   input  logic             force_div,
   input  logic             conflict,
   input  logic             div_wr_en,
   input  logic             prot_en,
   input  logic [DIV_W-1:0] div_wr_data,
   output logic [CW_W-1:0]  cw_q,
   output logic [DIV_W-1:0] div_q,
   output logic             err_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cw_q  <= CW_RST;
         div_q <= DIV_RST;
         err_q <= 1'b0;
      end else begin
         cw_q <= nxt;
         if (conflict)
            err_q <= 1'b1;
         if (force_div)
            div_q <= DIV_FORCE;
         else if (div_wr_en && prot_en)
            div_q <= div_wr_data;
      end
   end
endmodule

// File: rtl/clkctl_outmux.sv
module clkctl_outmux
   import clkctl_pkg::*;
#(
   parameter int FA_LOG2     = 3,
   parameter int FB_LOG2     = 5,
   parameter bit WRAP_SWITCH = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel_req,
   input  logic       fc_in,
   output logic       clk_out
);
   localparam int CNT_W = FB_LOG2;

   logic [CNT_W-1:0] cnt;
   logic             wrap;
   osel_e            sel_act;

   assign wrap = &cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   generate
      if (WRAP_SWITCH) begin : g_wrap
         osel_e sel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sel_q <= OSEL_PORT;
            else if (wrap)
               sel_q <= osel_e'(sel_req);
         end
         assign sel_act = sel_q;
      end else begin : g_live
         logic unused_wrap;
         assign unused_wrap = wrap;
         assign sel_act = osel_e'(sel_req);
      end
   endgenerate

   always_comb begin
      unique case (sel_act)
         OSEL_PORT: clk_out = 1'b0;
         OSEL_FC:   clk_out = fc_in;
         OSEL_FA:   clk_out = cnt[FA_LOG2-1];
         OSEL_FB:   clk_out = cnt[FB_LOG2-1];
         default:   clk_out = 1'b0;
      endcase
   end
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
   import clkctl_pkg::*;
#(
   parameter int               DIV_W       = 5,
   parameter logic [DIV_W-1:0] DIV_RST     = 5'b01000,
   parameter logic [DIV_W-1:0] DIV_FORCE   = 5'b01000,
   parameter int               FA_LOG2     = 3,
   parameter int               FB_LOG2     = 5,
   parameter bit               WRAP_SWITCH = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             prot_en,
   input  logic             chg_lock,
   input  logic             oco_mode,
   input  logic             stop_entry,
   input  logic             wait_mode,
   input  logic             div_wr_en,
   input  logic [DIV_W-1:0] div_wr_data,
   input  logic             fc_in,
   output logic [7:0]       rd_data,
   output logic [DIV_W-1:0] div_ratio,
   output logic             seq_err,
   output logic             clk_out,
   output logic             cpu_sub_sel,
   output logic             main_osc_run,
   output logic             xc_osc_en,
   output logic             xc_drive_hi,
   output logic             wdt_reset_mode,
   output logic             periph_run,
   output logic             fc32_run
);
   generate
      if (FA_LOG2 < 1 || FB_LOG2 <= FA_LOG2) begin : g_bad_taps
         $error("clkctl_top: output taps need 1 <= FA_LOG2 < FB_LOG2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("clkctl_top: DIV_W must be positive");
      end
   endgenerate

   logic [CW_W-1:0] cw_q;
   logic [CW_W-1:0] cw_nxt;
   logic            force_div;
   logic            conflict;

   clkctl_wfilter u_filt (
      .cur        (cw_q),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .prot_en    (prot_en),
      .chg_lock   (chg_lock),
      .oco_mode   (oco_mode),
      .stop_entry (stop_entry),
      .nxt        (cw_nxt),
      .force_div  (force_div),
      .conflict   (conflict)
   );

   clkctl_store #(
      .DIV_W     (DIV_W),
      .DIV_RST   (DIV_RST),
      .DIV_FORCE (DIV_FORCE)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .nxt         (cw_nxt),
      .force_div   (force_div),
      .conflict    (conflict),
      .div_wr_en   (div_wr_en),
      .prot_en     (prot_en),
      .div_wr_data (div_wr_data),
      .cw_q        (cw_q),
      .div_q       (div_ratio),
      .err_q       (seq_err)
   );

   clkctl_outmux #(
      .FA_LOG2     (FA_LOG2),
      .FB_LOG2     (FB_LOG2),
      .WRAP_SWITCH (WRAP_SWITCH)
   ) u_omux (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_req (cw_q[1:0]),
      .fc_in   (fc_in),
      .clk_out (clk_out)
   );

   assign rd_data        = cw_q;
   assign cpu_sub_sel    = cw_q[B_CPUSUB];
   assign main_osc_run   = ~cw_q[B_MSTOP];
   assign xc_osc_en      = cw_q[B_XCEN];
   assign xc_drive_hi    = cw_q[B_XDRV];
   assign wdt_reset_mode = cw_q[B_WDRST];
   assign periph_run     = ~(wait_mode & cw_q[B_PGATE]);
   assign fc32_run       = 1'b1;
endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk #(
   parameter int               DIV_W     = 5,
   parameter logic [DIV_W-1:0] DIV_FORCE = 5'b01000
)(
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [7:0]       wr_data,
   input logic             prot_en,
   input logic             chg_lock,
   input logic             oco_mode,
   input logic             stop_entry,
   input logic [7:0]       rd_data,
   input logic [DIV_W-1:0] div_ratio,
   input logic             seq_err
);
   assert_prot_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!prot_en && !stop_entry) |=> $stable(rd_data));

   assert_prot_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !prot_en |=> $stable(div_ratio));

   assert_lock_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      chg_lock |=> ($stable(rd_data[7]) && $stable(rd_data[5]) && $stable(rd_data[2])));

   assert_wdt_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[6] |=> rd_data[6]);

   assert_div_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && prot_en && !chg_lock && wr_data[5] && !oco_mode) |=> (div_ratio == DIV_FORCE));

   assert_stop_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_entry |=> rd_data[3]);

   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);
endmodule

bind clkctl_top clkctl_chk #(
   .DIV_W     (DIV_W),
   .DIV_FORCE (DIV_FORCE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .prot_en    (prot_en),
   .chg_lock   (chg_lock),
   .oco_mode   (oco_mode),
   .stop_entry (stop_entry),
   .rd_data    (rd_data),
   .div_ratio  (div_ratio),
   .seq_err    (seq_err)
);

// File: tb/tb_clkctl_top.sv
`timescale 1ns/1ps
module tb_clkctl_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       prot_en = 1'b0;
   logic       chg_lock = 1'b0;
   logic       oco_mode = 1'b0;
   logic       stop_entry = 1'b0;
   logic       wait_mode = 1'b0;
   logic       div_wr_en = 1'b0;
   logic [4:0] div_wr_data = '0;
   logic       fc_in = 1'b0;
   logic [7:0] rd_data;
   logic [4:0] div_ratio;
   logic       seq_err, clk_out, cpu_sub_sel, main_osc_run, xc_osc_en;
   logic       xc_drive_hi, wdt_reset_mode, periph_run, fc32_run;

   int nchk = 0;
   int nfail = 0;

   logic [7:0] m_cw;
   logic [4:0] m_div;
   logic       m_err;
   logic [4:0] m_cnt;
   logic [1:0] m_sel;

   always #10 clk = ~clk;

   clkctl_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .prot_en(prot_en), .chg_lock(chg_lock), .oco_mode(oco_mode),
      .stop_entry(stop_entry), .wait_mode(wait_mode), .div_wr_en(div_wr_en),
      .div_wr_data(div_wr_data), .fc_in(fc_in), .rd_data(rd_data),
      .div_ratio(div_ratio), .seq_err(seq_err), .clk_out(clk_out),
      .cpu_sub_sel(cpu_sub_sel), .main_osc_run(main_osc_run),
      .xc_osc_en(xc_osc_en), .xc_drive_hi(xc_drive_hi),
      .wdt_reset_mode(wdt_reset_mode), .periph_run(periph_run),
      .fc32_run(fc32_run)
   );

   // output-pin model: counter and wrap-aligned selection (R7)
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= '0;
         m_sel <= 2'b00;
      end else begin
         if (m_cnt == 5'd31)
            m_sel <= rd_data[1:0];
         m_cnt <= m_cnt + 5'd1;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 1'b0; div_wr_en = 1'b0; stop_entry = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_cw = 8'h08; m_div = 5'b01000; m_err = 1'b0;
   endtask

   task automatic step(input logic [7:0] d, input bit we, input bit pr, input bit lk,
                       input bit oc, input bit st, input bit dwe, input logic [4:0] dd,
                       input bit wt);
      logic [7:0] c;
      logic       acc;
      wr_data = d; wr_en = we; prot_en = pr; chg_lock = lk; oco_mode = oc;
      stop_entry = st; div_wr_en = dwe; div_wr_data = dd; wait_mode = wt;
      acc = we & pr;
      c = acc ? d : m_cw;
      if (lk) begin
         c[2] = m_cw[2]; c[5] = m_cw[5]; c[7] = m_cw[7];
      end
      c[6] = m_cw[6] | (acc & d[6]);
      if ((c[7] != m_cw[7]) && ((c[4] != m_cw[4]) || (c[5] != m_cw[5]))) begin
         c[7] = m_cw[7];
         m_err = 1'b1;
      end
      if (st) c[3] = 1'b1;
      if (acc && !lk && d[5] && !oc) m_div = 5'b01000;
      else if (dwe && pr) m_div = dd;
      @(posedge clk);
      m_cw = c;
      @(negedge clk);
      wr_en = 1'b0; div_wr_en = 1'b0; stop_entry = 1'b0;
      check(rd_data == m_cw, "R2/R3/R4/R6/R10 word", rd_data, m_cw);
      check(div_ratio == m_div, "R5/R11 divide ratio", div_ratio, m_div);
      check(seq_err == m_err, "R10 seq_err", seq_err, m_err);
      check({cpu_sub_sel, main_osc_run, xc_osc_en, xc_drive_hi, wdt_reset_mode} ==
            {m_cw[7], ~m_cw[5], m_cw[4], m_cw[3], m_cw[6]}, "R8 decodes",
            {cpu_sub_sel, main_osc_run, xc_osc_en, xc_drive_hi, wdt_reset_mode},
            {m_cw[7], ~m_cw[5], m_cw[4], m_cw[3], m_cw[6]});
      check(periph_run == ~(wt & m_cw[2]) && fc32_run, "R9 gating",
            {periph_run, fc32_run}, {~(wt & m_cw[2]), 1'b1});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin : main
      do_reset();
      @(negedge clk);
      // R1 reset state
      check(rd_data == 8'h08, "R1 word", rd_data, 8'h08);
      check(div_ratio == 5'b01000, "R1 div", div_ratio, 5'b01000);
      check(seq_err == 1'b0, "R1 err", seq_err, 0);
      check(clk_out == 1'b0, "R1 clk_out", clk_out, 0);

      // directed: R10 refused switch, R5 force vs oco and vs divide write
      step(8'h98, 1, 1, 0, 0, 0, 0, 5'd0, 0);
      check(rd_data[7] == 1'b0 && seq_err, "R10 switch refused", rd_data, 8'h18);
      step(8'h38, 1, 1, 0, 1, 0, 1, 5'd3, 0);
      check(div_ratio == 5'd3, "R5 oco keeps div write", div_ratio, 3);
      step(8'h18, 1, 1, 0, 0, 0, 0, 5'd0, 0);
      step(8'h38, 1, 1, 0, 0, 0, 1, 5'd17, 0);
      check(div_ratio == 5'b01000, "R5 force wins", div_ratio, 8);
      step(8'h40, 1, 1, 0, 0, 0, 0, 5'd0, 0);
      step(8'h00, 1, 1, 0, 0, 0, 0, 5'd0, 0);
      check(rd_data[6] == 1'b1, "R4 bit6 sticky", rd_data, 8'h40);

      // sweeps over all bytes under each protect/lock setting
      for (int ph = 0; ph < 4; ph++) begin
         for (int d = 0; d < 256; d++) begin
            if (d % 64 == 0) do_reset();
            step(8'(d), 1'b1, ph[1] | (d % 5 != 0), ph[0], d[7] ^ d[0],
                 (d % 13 == 5), (d % 7 == 3), 5'(d) ^ 5'h15, d[1]);
         end
      end

      // R7 output pin selection, switching only at counter wrap
      for (int s = 0; s < 4; s++) begin
         do_reset();
         step({6'b0, 2'(s)}, 1, 1, 0, 0, 0, 0, 5'd0, 0);
         for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            fc_in = (k % 3 == 1);
            #1;
            begin
               logic e;
               case (m_sel)
                  2'b00: e = 1'b0;
                  2'b01: e = fc_in;
                  2'b10: e = m_cnt[2];
                  default: e = m_cnt[4];
               endcase
               check(clk_out == e, "R7 clk_out", clk_out, e);
            end
            if (k == 40) step({6'b0, 2'(3 - s)}, 1, 1, 0, 0, 0, 0, 5'd0, 0);
         end
      end

      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule